// File: doc/BRIEF.md
# Segmented Dual-Slope Conversion Sequencer

This block is the digital sequencer of a single-polarity dual-slope converter. The converter measures slowly varying quantities. It connects the input to an external integrator and counts clocks. Once an external comparator reports that the integrator has passed its threshold, the block ends the integration phase. It does so only on a fixed grid of `2**GRID_LOG2` clocks, so the integration length is always a whole number of grid slots. It then connects a discharge source and counts clocks again until a second comparator reports that the integrator is back at its starting level. The two counts are published together with a one-cycle strobe. Downstream logic divides them to obtain the input level.

A one-cycle gap with both switches open separates every hand-over between input and discharge. Input offset can cancel the signal so that the threshold is never reached. If the integration counter reaches its full range without a crossing, the block publishes a zero result marked as overflow, toggles its chop request so the input polarity is swapped, and starts a new integration. The first result after reset is marked because the integrator did not start from its settled level.

Top module: `sdsc_sequencer`

## Requirements
- R1: After reset the input switch enable is 1, the discharge switch enable is 0, the valid strobe is 0 and the chop request is 0.
- R2: The integration phase lasts j cycles, where j is the first multiple of the grid `G = 2**GRID_LOG2` for which the threshold flag is high on the clock edge ending cycle j. The published integration count equals j. Its low GRID_LOG2 bits are therefore zero, and its minimum is G.
- R3: A threshold flag that is high on an edge that is not a grid point has no effect: integration continues to the next grid point.
- R4: Whenever the input switch enable falls without an overflow, both enables are low for exactly one cycle before the discharge switch enable rises. After the discharge ends, both enables are low for exactly one cycle before the input switch enable rises. The two enables are never high together.
- R5: The published discharge count equals the number of cycles the discharge switch enable was high, counting the cycle whose ending edge sampled the done flag. The count saturates at `2**DCNT_W-1`.
- R6: The valid strobe is high for exactly one cycle, in the cycle after the edge that ends the discharge phase. The counts and flags are stable while it is high.
- R7: If `2**CNT_W` integration cycles pass with no grid-point threshold crossing, the block raises the valid strobe in the next cycle with both counts 0 and the overflow flag 1. The input switch stays closed and a new integration starts with its count at zero.
- R8: The chop request toggles at each overflow and changes at no other time.
- R9: The first-result flag is 1 on the first valid result after reset, whether that result is normal or an overflow, and 0 on every later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| thr_hit | input | 1 | Synchronized flag: integrator above threshold |
| dis_done | input | 1 | Synchronized flag: integrator back at starting level |
| in_sw_en | output | 1 | Close the input switch |
| dis_sw_en | output | 1 | Close the discharge switch |
| chop | output | 1 | Input polarity swap request |
| res_valid | output | 1 | One-cycle result strobe |
| res_first | output | 1 | Result is the first after reset |
| res_ovf | output | 1 | Result came from a lock-up overflow |
| res_icount | output | CNT_W+1 | Integration cycles of the conversion |
| res_dcount | output | DCNT_W | Discharge cycles of the conversion |

## Verification
The properties assume that both comparator flags are already synchronous to the clock. They also assume that the integration range of `2**CNT_W` cycles is far longer than the valid strobe, so two results can never fall in adjacent cycles. The bench meets both assumptions. It drives the flags from a small integrator model at the falling edge. That model raises the threshold after a chosen number of input-enabled cycles and raises the done flag after a chosen number of discharge-enabled cycles. It sweeps the threshold delay across every value from 0 to just past the overflow range of a reduced configuration. This covers off-grid crossings, the largest count that still fits, overflow and discharge saturation.

// File: rtl/sdsc_pkg.sv
package sdsc_pkg;

    typedef enum logic [1:0] {
        PH_INTEG  = 2'd0,
        PH_GAP_ID = 2'd1,
        PH_DISCH  = 2'd2,
        PH_GAP_DI = 2'd3
    } sdsc_phase_e;

endpackage

// File: rtl/sdsc_int_counter.sv
module sdsc_int_counter #(
    parameter int CNT_W     = 16,
    parameter int GRID_LOG2 = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] cnt_q,
    output logic             grid_edge,
    output logic             wrap_edge
);
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // the next increment moves bit GRID_LOG2 / wraps the whole counter
    assign grid_edge = &cnt_q[GRID_LOG2-1:0];
    assign wrap_edge = &cnt_q;

endmodule

// File: rtl/sdsc_dis_counter.sv
module sdsc_dis_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt_inc
);
    logic [W-1:0] cnt_q, cnt_d;

    // saturating increment
    assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + W'(1);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en) begin
            cnt_d = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/sdsc_sequencer.sv
module sdsc_sequencer
    import sdsc_pkg::*;
#(
    parameter int GRID_LOG2 = 7,
    parameter int CNT_W     = 16,
    parameter int DCNT_W    = 16,
    localparam int RES_IW   = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thr_hit,
    input  logic              dis_done,
    output logic              in_sw_en,
    output logic              dis_sw_en,
    output logic              chop,
    output logic              res_valid,
    output logic              res_first,
    output logic              res_ovf,
    output logic [RES_IW-1:0] res_icount,
    output logic [DCNT_W-1:0] res_dcount
);
    typedef struct packed {
        sdsc_phase_e       phase;
        logic [RES_IW-1:0] int_len;
        logic [RES_IW-1:0] res_i;
        logic [DCNT_W-1:0] res_d;
        logic              valid;
        logic              ovf;
        logic              first;
        logic              first_pend;
        logic              chop;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        phase:      PH_INTEG,
        int_len:    '0,
        res_i:      '0,
        res_d:      '0,
        valid:      1'b0,
        ovf:        1'b0,
        first:      1'b0,
        first_pend: 1'b1,
        chop:       1'b0
    };

    seq_t seq_d, seq_q;

    logic              icnt_clr, icnt_en, dcnt_clr, dcnt_en;
    logic [CNT_W-1:0]  icnt;
    logic              grid_edge, wrap_edge;
    logic [DCNT_W-1:0] dcnt_inc;

    sdsc_int_counter #(
        .CNT_W    (CNT_W),
        .GRID_LOG2(GRID_LOG2)
    ) u_icnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (icnt_clr),
        .en       (icnt_en),
        .cnt_q    (icnt),
        .grid_edge(grid_edge),
        .wrap_edge(wrap_edge)
    );

    sdsc_dis_counter #(
        .W(DCNT_W)
    ) u_dcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (dcnt_clr),
        .en     (dcnt_en),
        .cnt_inc(dcnt_inc)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.valid = 1'b0;
        icnt_clr    = 1'b0;
        icnt_en     = 1'b0;
        dcnt_clr    = 1'b0;
        dcnt_en     = 1'b0;

        unique case (seq_q.phase)
            PH_INTEG: begin
                icnt_en = 1'b1;
                if (grid_edge && thr_hit) begin
                    seq_d.phase   = PH_GAP_ID;
                    seq_d.int_len = RES_IW'(icnt) + RES_IW'(1);
                end else if (wrap_edge) begin
                    // lock-up: zero result, swap polarity, integrate again
                    icnt_clr         = 1'b1;
                    seq_d.valid      = 1'b1;
                    seq_d.ovf        = 1'b1;
                    seq_d.res_i      = '0;
                    seq_d.res_d      = '0;
                    seq_d.chop       = ~seq_q.chop;
                    seq_d.first      = seq_q.first_pend;
                    seq_d.first_pend = 1'b0;
                end
            end
            PH_GAP_ID: begin
                dcnt_clr    = 1'b1;
                seq_d.phase = PH_DISCH;
            end
            PH_DISCH: begin
                dcnt_en = 1'b1;
                if (dis_done) begin
                    seq_d.phase      = PH_GAP_DI;
                    seq_d.valid      = 1'b1;
                    seq_d.ovf        = 1'b0;
                    seq_d.res_i      = seq_q.int_len;
                    seq_d.res_d      = dcnt_inc;
                    seq_d.first      = seq_q.first_pend;
                    seq_d.first_pend = 1'b0;
                end
            end
            PH_GAP_DI: begin
                icnt_clr    = 1'b1;
                seq_d.phase = PH_INTEG;
            end
            default: seq_d.phase = PH_INTEG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign in_sw_en   = (seq_q.phase == PH_INTEG);
    assign dis_sw_en  = (seq_q.phase == PH_DISCH);
    assign chop       = seq_q.chop;
    assign res_valid  = seq_q.valid;
    assign res_first  = seq_q.first;
    assign res_ovf    = seq_q.ovf;
    assign res_icount = seq_q.res_i;
    assign res_dcount = seq_q.res_d;

endmodule

// File: rtl/sdsc_sequencer_chk.sv
module sdsc_sequencer_chk #(
    parameter int GRID_LOG2 = 7,
    parameter int CNT_W     = 16,
    parameter int DCNT_W    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_sw_en,
    input logic              dis_sw_en,
    input logic              chop,
    input logic              res_valid,
    input logic              res_ovf,
    input logic [CNT_W:0]    res_icount,
    input logic [DCNT_W-1:0] res_dcount
);
    // R4
    switch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_sw_en && dis_sw_en));

    // R4
    gap_before_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dis_sw_en) |-> $past(!in_sw_en));

    // R4
    gap_before_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sw_en) |-> $past(!dis_sw_en));

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R2
    grid_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ovf) |->
            (res_icount[GRID_LOG2-1:0] == '0) && (res_icount != '0));

    // R5
    dis_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ovf) |-> (res_dcount != '0));

    // R7
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ovf) |-> (res_icount == '0) && (res_dcount == '0) && in_sw_en);

    // R8
    chop_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chop != $past(chop)) |-> (res_valid && res_ovf));

endmodule

bind sdsc_sequencer sdsc_sequencer_chk #(
    .GRID_LOG2(GRID_LOG2),
    .CNT_W    (CNT_W),
    .DCNT_W   (DCNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_sw_en  (in_sw_en),
    .dis_sw_en (dis_sw_en),
    .chop      (chop),
    .res_valid (res_valid),
    .res_ovf   (res_ovf),
    .res_icount(res_icount),
    .res_dcount(res_dcount)
);

// File: tb/tb_sdsc_sequencer.sv
`timescale 1ns/1ps
module tb_sdsc_sequencer;
    localparam int GL   = 3;
    localparam int CW   = 6;
    localparam int DW   = 4;
    localparam int G    = 1 << GL;
    localparam int IMAX = 1 << CW;
    localparam int DMAX = (1 << DW) - 1;
    localparam int NRUN = IMAX + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic thr_hit = 1'b0;
    logic dis_done = 1'b0;
    logic in_sw_en, dis_sw_en, chop, res_valid, res_first, res_ovf;
    logic [CW:0]   res_icount;
    logic [DW-1:0] res_dcount;

    always #4 clk = ~clk;

    sdsc_sequencer #(.GRID_LOG2(GL), .CNT_W(CW), .DCNT_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .thr_hit(thr_hit), .dis_done(dis_done),
        .in_sw_en(in_sw_en), .dis_sw_en(dis_sw_en), .chop(chop),
        .res_valid(res_valid), .res_first(res_first), .res_ovf(res_ovf),
        .res_icount(res_icount), .res_dcount(res_dcount)
    );

    int n_chk = 0;
    int n_fail = 0;
    int thr_t = 0;
    int dis_t = 1;
    int idx = 0;
    int ic = 0;
    int dc = 0;
    int dz_viol = 0;
    int cycles = 0;
    bit prev_in = 1'b1;
    bit prev_dis = 1'b0;
    bit chop_exp = 1'b0;
    bit sweep_done = 1'b0;
    bit timeout = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s idx=%0d actual=%0d expected=%0d", req, idx, act, exp);
        end
    endtask

    function automatic int dis_of(input int i);
        return 1 + ((i * 7) % 18);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) timeout = 1'b1;
    end

    // falling-edge integrator model and result checking
    always @(negedge clk) begin
        if (!rst_n) begin
            ic = 0;
            dc = 0;
        end else if (!sweep_done) begin
            // R4 switch gap monitor
            if (in_sw_en && dis_sw_en) dz_viol++;
            if (dis_sw_en && prev_in) dz_viol++;
            if (in_sw_en && prev_dis) dz_viol++;
            if (!in_sw_en && !dis_sw_en && !prev_in && !prev_dis) dz_viol++;
            prev_in  = in_sw_en;
            prev_dis = dis_sw_en;

            if (res_valid) begin : result
                bit ovf_e;
                int len_e, d_e;
                ovf_e = (thr_t > IMAX);
                len_e = (thr_t == 0) ? G : G * ((thr_t + G - 1) / G);
                d_e   = (dis_t > DMAX) ? DMAX : dis_t;
                if (ovf_e) begin
                    len_e = 0;
                    d_e   = 0;
                end
                chop_exp ^= ovf_e;
                chk(res_ovf == ovf_e, "R7 overflow flag", int'(res_ovf), int'(ovf_e));
                chk(int'(res_icount) == len_e, "R2 R3 integration count", int'(res_icount), len_e);
                chk(int'(res_dcount) == d_e, "R5 discharge count", int'(res_dcount), d_e);
                chk(chop == chop_exp, "R8 chop", int'(chop), int'(chop_exp));
                chk(res_first == (idx == 0), "R9 first flag", int'(res_first), int'(idx == 0));
                idx++;
                if (idx >= NRUN) begin
                    sweep_done = 1'b1;
                end else begin
                    thr_t = idx;
                    dis_t = dis_of(idx);
                end
            end

            if (in_sw_en) ic = (res_valid && res_ovf) ? 1 : ic + 1;
            else          ic = 0;
            if (dis_sw_en) dc = dc + 1;
            else           dc = 0;
            thr_hit  = (ic >= thr_t);
            dis_done = (dc >= dis_t);
        end
    end

    initial begin
        thr_t = 0;
        dis_t = dis_of(0);
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(in_sw_en == 1'b1, "R1 input enable", int'(in_sw_en), 1);
        chk(dis_sw_en == 1'b0, "R1 discharge enable", int'(dis_sw_en), 0);
        chk(res_valid == 1'b0, "R1 valid", int'(res_valid), 0);
        chk(chop == 1'b0, "R1 chop", int'(chop), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        wait (sweep_done || timeout);
        @(negedge clk);
        chk(!timeout, "watchdog", int'(timeout), 0);
        chk(dz_viol == 0, "R4 switch gap violations", dz_viol, 0);
        chk(idx == NRUN, "R6 result count", idx, NRUN);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule